// File: doc/BRIEF.md
# DSP Condition Bit Update Unit

This block keeps the single condition bit of a fixed-point DSP datapath. After each ALU or shifter operation it takes the 40-bit result and the side signals the datapath produces. These are the carry or borrow out, the last bit shifted out and a full-width signed overflow indication. From them it forms one new condition value and registers it when the update strobe is high.

A 3-bit software-selected mode picks the rule used to form the value. The six legal rules are carry/borrow, negative, zero, word overflow, signed greater-or-equal and signed greater-than. Each rule treats arithmetic and logical operations differently. The 40-bit result has 8 guard bits (39:32) above a 32-bit destination word (31:0). The negative, overflow and signed-compare rules depend on which part of the result they look at. The two spare mode codes leave the bit unchanged.

Top module: `condBitUnit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `condBit` is 0 after that edge, whatever the other inputs are.
- R2: When `updEn` is low at a rising edge (and `rst` is low), `condBit` keeps its value.
- R3: Mode 3'b000 (carry): for an ALU arithmetic operation (`opClass` 2'b00) the bit takes `carryOut`. For either shift (`opClass` 2'b10 arithmetic, 2'b11 logical) it takes `shiftOut`. For an ALU logical operation (`opClass` 2'b01) it becomes 0.
- R4: Mode 3'b001 (negative): for arithmetic classes (2'b00, 2'b10) the bit takes `result[39]`. For logical classes (2'b01, 2'b11) it takes `result[31]`.
- R5: Mode 3'b010 (zero): for every operation class, the bit is 1 exactly when all 40 result bits are 0.
- R6: Mode 3'b011 (overflow): for arithmetic classes, the bit is 1 exactly when the signed 40-bit result lies outside the signed 32-bit range, that is, when bits 39:31 are not all equal. For logical classes it is 0.
- R7: Mode 3'b101 (greater-or-equal): for arithmetic classes, the bit is the inverse of (`result[39]` XOR `overRange`). For logical classes it is 0.
- R8: Mode 3'b100 (greater-than): for arithmetic classes, the bit is the inverse of ((`result[39]` XOR `overRange`) OR result-is-zero). For logical classes it is 0.
- R9: Mode codes 3'b110 and 3'b111 are reserved. An update strobe under either code leaves `condBit` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| updEn | input | 1 | Update strobe for the current operation |
| modeSel | input | 3 | Condition rule selector |
| opClass | input | 2 | 00 ALU arithmetic, 01 ALU logical, 10 arithmetic shift, 11 logical shift |
| result | input | 40 | Operation result, guard bits 39:32, word 31:0 |
| carryOut | input | 1 | Carry or borrow out of the ALU |
| shiftOut | input | 1 | Last bit shifted out |
| overRange | input | 1 | Signed overflow of the full 40-bit operation |
| condBit | output | 1 | Registered condition bit |

## Verification
Directed results are applied under every mode and every operation class. They include all-zero, a lone set guard bit, a lone bit 31, the exact word limits 0x7FFFFFFF and -0x80000000, and the values one step beyond them. These separate the rules that read guard bit 39 from those that read bit 31, and they show whether the zero test reaches into the guard bits. Pairs that differ only in `carryOut`, `shiftOut` or `overRange` show that each rule reads the right side signal for the right class. Long random runs mix strobed and unstrobed cycles, reserved codes and resets, and a behavioural model follows them every clock.

// File: rtl/condBitPkg.sv
package condBitPkg;

  // Which candidate value the datapath loads into the condition register.
  typedef enum logic [3:0] {
    SRC_CLEAR   = 4'd0,
    SRC_CARRY   = 4'd1,
    SRC_SHIFT   = 4'd2,
    SRC_NEGFULL = 4'd3,
    SRC_NEGWORD = 4'd4,
    SRC_ZERO    = 4'd5,
    SRC_OVF     = 4'd6,
    SRC_GE      = 4'd7,
    SRC_GT      = 4'd8
  } srcSel_t;

  typedef enum logic [1:0] {
    OP_ALU_ARITH = 2'b00,
    OP_ALU_LOGIC = 2'b01,
    OP_SH_ARITH  = 2'b10,
    OP_SH_LOGIC  = 2'b11
  } opClass_t;

  typedef enum logic [2:0] {
    MODE_CARRY = 3'b000,
    MODE_NEG   = 3'b001,
    MODE_ZERO  = 3'b010,
    MODE_OVF   = 3'b011,
    MODE_GT    = 3'b100,
    MODE_GE    = 3'b101,
    MODE_RSV0  = 3'b110,
    MODE_RSV1  = 3'b111
  } mode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    load;
    srcSel_t src;
  } ctrlStrobe_t;

endpackage

// File: rtl/condBitCtrl.sv
module condBitCtrl
  import condBitPkg::*;
(
  input  logic        updEn,
  input  logic [2:0]  modeSel,
  input  logic [1:0]  opClass,
  output ctrlStrobe_t strobe
);

  logic isArith;
  logic isShift;
  logic legalMode;

  assign isArith   = (opClass == OP_ALU_ARITH) || (opClass == OP_SH_ARITH);
  assign isShift   = opClass[1];
  assign legalMode = (modeSel != MODE_RSV0) && (modeSel != MODE_RSV1);

  always_comb begin
    strobe.load = updEn && legalMode;
    strobe.src  = SRC_CLEAR;
    unique case (modeSel)
      MODE_CARRY: begin
        if (isShift)                      strobe.src = SRC_SHIFT;
        else if (opClass == OP_ALU_ARITH) strobe.src = SRC_CARRY;
        else                              strobe.src = SRC_CLEAR;
      end
      MODE_NEG:  strobe.src = isArith ? SRC_NEGFULL : SRC_NEGWORD;
      MODE_ZERO: strobe.src = SRC_ZERO;
      MODE_OVF:  strobe.src = isArith ? SRC_OVF : SRC_CLEAR;
      MODE_GT:   strobe.src = isArith ? SRC_GT  : SRC_CLEAR;
      MODE_GE:   strobe.src = isArith ? SRC_GE  : SRC_CLEAR;
      default:   strobe.src = SRC_CLEAR;
    endcase
  end

endmodule

// File: rtl/condBitData.sv
module condBitData
  import condBitPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobe_t                 strobe,
  input  logic [WORD_W+GUARD_W-1:0]   result,
  input  logic                        carryOut,
  input  logic                        shiftOut,
  input  logic                        overRange,
  output logic                        condBit
);

  localparam int RES_W = WORD_W + GUARD_W;
  localparam int TOP_W = GUARD_W + 1;   // guard bits plus word sign bit

  logic [TOP_W-1:0] topBits;
  logic negFull;
  logic negWord;
  logic isZero;
  logic wordOvf;
  logic signMismatch;
  logic geBit;
  logic gtBit;
  logic nextBit;

  assign topBits = result[RES_W-1:WORD_W-1];
  assign negFull = result[RES_W-1];
  assign negWord = result[WORD_W-1];
  assign isZero  = ~|result;

  // Word overflow: guard bits are not a sign extension of the word.
  generate
    if (GUARD_W > 0) begin : g_ovf
      assign wordOvf = ~((&topBits) | (~|topBits));
    end else begin : g_noOvf
      assign wordOvf = 1'b0;
    end
  endgenerate

  assign signMismatch = negFull ^ overRange;
  assign geBit        = ~signMismatch;
  assign gtBit        = ~(signMismatch | isZero);

  always_comb begin
    unique case (strobe.src)
      SRC_CARRY:   nextBit = carryOut;
      SRC_SHIFT:   nextBit = shiftOut;
      SRC_NEGFULL: nextBit = negFull;
      SRC_NEGWORD: nextBit = negWord;
      SRC_ZERO:    nextBit = isZero;
      SRC_OVF:     nextBit = wordOvf;
      SRC_GE:      nextBit = geBit;
      SRC_GT:      nextBit = gtBit;
      default:     nextBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              condBit <= 1'b0;
    else if (strobe.load) condBit <= nextBit;
  end

endmodule

// File: rtl/condBitUnit.sv
module condBitUnit
  import condBitPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      updEn,
  input  logic [2:0]                modeSel,
  input  logic [1:0]                opClass,
  input  logic [WORD_W+GUARD_W-1:0] result,
  input  logic                      carryOut,
  input  logic                      shiftOut,
  input  logic                      overRange,
  output logic                      condBit
);

  ctrlStrobe_t strobe;

  condBitCtrl u_ctrl (
    .updEn   (updEn),
    .modeSel (modeSel),
    .opClass (opClass),
    .strobe  (strobe)
  );

  condBitData #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .result    (result),
    .carryOut  (carryOut),
    .shiftOut  (shiftOut),
    .overRange (overRange),
    .condBit   (condBit)
  );

endmodule

// File: rtl/condBitUnit_chk.sv
module condBitUnit_chk #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      updEn,
  input logic [2:0]                modeSel,
  input logic [1:0]                opClass,
  input logic [WORD_W+GUARD_W-1:0] result,
  input logic                      carryOut,
  input logic                      shiftOut,
  input logic                      overRange,
  input logic                      condBit
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !condBit);

  p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !updEn |=> $stable(condBit));

  p_carry_arith_r3: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b000 && opClass == 2'b00) |=> (condBit == $past(carryOut)));

  p_carry_logic_r3: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b000 && opClass == 2'b01) |=> !condBit);

  p_neg_word_r4: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b001 && opClass[0]) |=> (condBit == $past(result[WORD_W-1])));

  p_zero_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b010 && result == '0) |=> condBit);

  p_ovf_logic_r6: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b011 && opClass[0]) |=> !condBit);

  p_ge_logic_r7: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b101 && opClass[0]) |=> !condBit);

  p_gt_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (updEn && modeSel == 3'b100 && result == '0) |=> !condBit);

  p_reserved_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (modeSel[2:1] == 2'b11) |=> $stable(condBit));

endmodule

bind condBitUnit condBitUnit_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .updEn     (updEn),
  .modeSel   (modeSel),
  .opClass   (opClass),
  .result    (result),
  .carryOut  (carryOut),
  .shiftOut  (shiftOut),
  .overRange (overRange),
  .condBit   (condBit)
);

// File: tb/condBitUnit_bench.sv
module condBitUnit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        updEn = 1'b0;
  logic [2:0]  modeSel = 3'b000;
  logic [1:0]  opClass = 2'b00;
  logic [39:0] result = '0;
  logic        carryOut = 1'b0;
  logic        shiftOut = 1'b0;
  logic        overRange = 1'b0;
  logic        condBit;

  int errors = 0;
  int checks = 0;
  bit modelBit = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  condBitUnit u_condBitUnit (
    .clk(clk), .rst(rst), .updEn(updEn), .modeSel(modeSel), .opClass(opClass),
    .result(result), .carryOut(carryOut), .shiftOut(shiftOut),
    .overRange(overRange), .condBit(condBit)
  );

  // Behavioural expectation from the requirements.
  function automatic bit refNext(bit r, bit en, int mode, int cls, logic [39:0] res,
                                 bit cy, bit sh, bit ovr, bit prev);
    longint sv;
    bit arith;
    bit neg;
    if (r) return 1'b0;                          // R1
    if (!en) return prev;                        // R2
    sv    = longint'($signed(res));
    arith = (cls == 0) || (cls == 2);
    neg   = (sv < 0);
    case (mode)
      0: return (cls == 0) ? cy : (cls == 1) ? 1'b0 : sh;                      // R3
      1: return arith ? neg : res[31];                                          // R4
      2: return (sv == 0);                                                      // R5
      3: return arith && (sv > 64'sd2147483647 || sv < -64'sd2147483648);      // R6
      5: return arith && !(neg != ovr);                                         // R7
      4: return arith && !((neg != ovr) || sv == 0);                            // R8
      default: return prev;                                                     // R9
    endcase
  endfunction

  function automatic string tagOf(bit r, bit en, int mode);
    if (r) return "R1";
    if (!en) return "R2";
    case (mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      5: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Drive at negedge, let one posedge capture, compare at the following negedge.
  task automatic step(bit r, bit en, int mode, int cls, logic [39:0] res,
                      bit cy, bit sh, bit ovr);
    string tag;
    rst = r; updEn = en; modeSel = mode[2:0]; opClass = cls[1:0];
    result = res; carryOut = cy; shiftOut = sh; overRange = ovr;
    tag = tagOf(r, en, mode);
    @(posedge clk);
    modelBit = refNext(r, en, mode, cls, res, cy, sh, ovr, modelBit);
    @(negedge clk);
    checks++;
    if (condBit !== modelBit) begin
      errors++;
      $display("FAIL %s mode=%0d class=%0d result=%h actual=%0b expected=%0b",
               tag, mode, cls, res, condBit, modelBit);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [39:0] pats [10];
    pats[0] = 40'h00_0000_0000;  // zero
    pats[1] = 40'h01_0000_0000;  // lone guard bit
    pats[2] = 40'h00_8000_0000;  // bit 31 only: positive, overflowed
    pats[3] = 40'h00_7FFF_FFFF;  // word max
    pats[4] = 40'hFF_8000_0000;  // word min
    pats[5] = 40'hFF_7FFF_FFFF;  // word min minus one
    pats[6] = 40'h80_0000_0000;  // most negative 40-bit
    pats[7] = 40'hFF_FFFF_FFFF;  // minus one
    pats[8] = 40'h00_0000_0001;  // one
    pats[9] = 40'h7F_FFFF_FFFF;  // most positive 40-bit

    @(negedge clk);
    step(1, 1, 0, 0, 40'h1, 1, 1, 1);            // R1 reset state
    step(0, 1, 0, 0, 40'h5, 1, 0, 0);            // R3 carry in
    step(1, 1, 0, 0, 40'h5, 1, 0, 0);            // R1 reset over strobe
    step(0, 1, 2, 1, 40'h0, 0, 0, 0);            // R5 set bit
    step(0, 0, 0, 1, 40'h0, 0, 0, 0);            // R2 no strobe holds 1
    step(0, 1, 6, 1, 40'h5, 0, 0, 0);            // R9 reserved holds
    step(0, 1, 7, 0, 40'h5, 0, 0, 0);            // R9 reserved holds

    // Every mode, class, pattern and side-signal combination.
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 10; p++)
          for (int s = 0; s < 8; s++)
            step(0, 1, m, c, pats[p], s[0], s[1], s[2]);

    // Random mix with strobe gaps, reserved codes and occasional reset.
    for (int i = 0; i < 3000; i++) begin
      logic [39:0] rv;
      int kind = $urandom_range(0, 4);
      rv = {$urandom, $urandom};
      if (kind == 0) rv = '0;
      else if (kind == 1) rv = {{8{rv[31]}}, rv[31:0]};
      step(($urandom_range(0, 40) == 0), ($urandom_range(0, 3) != 0),
           $urandom_range(0, 7), $urandom_range(0, 3), rv,
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule